// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Port

This block gathers up to 32 interrupt request lines into one request line for a processor or a parent controller. Each line is fixed at build time as edge-sensitive or level-sensitive. A request is held in a status register until software acknowledges it. An enable register decides which held requests count as pending. Software reaches the block through a plain 32-bit register port that has a write strobe, a byte offset and a combinational read path.

Software enables sources one bit at a time, with no read-modify-write, through separate set and clear offsets. It finds the source to service by reading a vector register. That register gives the lowest-numbered pending source, or all ones when no source is pending, so a service routine can loop until it reads all ones. A two-bit master enable gates the output request line, and that line is registered.

Top module: `vec_intc`

## Requirements
- R1: After reset, status, enable and master enable read as zero, the vector reads 0xFFFFFFFF and irqOut is low.
- R2: Register byte offsets are status 0x00, pending 0x04, enable 0x08, acknowledge 0x0C, set-enable 0x10, clear-enable 0x14, vector 0x18 and master 0x1C. Any other offset is unmapped, and so is any offset whose two low bits are not zero. Writes to status, pending, vector or unmapped offsets change nothing. Reads of acknowledge, set-enable, clear-enable or unmapped offsets return zero.
- R3: A write to 0x10 ORs the data into enable, and a write to 0x14 clears the enable bits where the data is 1. Both leave the other enable bits as they were. A write to 0x08 replaces the whole enable register.
- R4: A write to 0x0C clears each status bit whose data bit is 1. Writing 0xFFFFFFFF clears every latched request unless a request arrives in that same cycle.
- R5: An edge input (EDGE_MASK bit = 1) sets its status bit once for each low-to-high change. While the input stays high after an acknowledge, the bit stays clear.
- R6: A level input (EDGE_MASK bit = 0) sets its status bit in every cycle in which it is high. If it is acknowledged while still high, the status bit stays set.
- R7: Pending reads as status AND enable.
- R8: The vector reads the index of the lowest-numbered pending bit, where index 0 has the highest priority. It reads 0xFFFFFFFF when nothing is pending.
- R9: The master register holds data bits 1:0 and reads back 0x3 after a write of 0x3. irqOut is high one cycle after both master bits are set and some pending bit is set, and low one cycle after either condition goes away.
- R10: Status and enable bits at or above NUM_IN always read zero. EDGE_MASK bits at or above NUM_IN have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_IN | Interrupt request lines, synchronous to clk |
| busAddr | input | ADDR_W | Register byte offset |
| busWe | input | 1 | Write strobe for this cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The bench acknowledges a level input while that input is still high. A design that failed to re-latch would lose the request. It also holds an edge input high across an acknowledge, where a design that latched on level would interrupt again at once. Atomic enable writes run against enable patterns that are already set, so a set or clear write that wiped the other bits would show in the readback. Other cases covered are two sources pending together to test vector priority, the all-ones vector once the last source is acknowledged, and the one-cycle latency of irqOut when only one master bit is set. Writes to misaligned, unmapped and read-only offsets go in while status and enable hold known non-zero values, so a decoder that let such a write through would alter a readback.

// File: rtl/vintc_pkg.sv
package vintc_pkg;

  // Byte offsets of the register port
  localparam logic [7:0] OFS_STATUS  = 8'h00;
  localparam logic [7:0] OFS_PENDING = 8'h04;
  localparam logic [7:0] OFS_ENABLE  = 8'h08;
  localparam logic [7:0] OFS_ACK     = 8'h0C;
  localparam logic [7:0] OFS_SETEN   = 8'h10;
  localparam logic [7:0] OFS_CLREN   = 8'h14;
  localparam logic [7:0] OFS_VECTOR  = 8'h18;
  localparam logic [7:0] OFS_MASTER  = 8'h1C;

  localparam logic [31:0] NO_VECTOR = 32'hFFFF_FFFF;

  // Write strobes from control to datapath
  typedef struct packed {
    logic wrEnable;
    logic setEnable;
    logic clrEnable;
    logic wrAck;
    logic wrMaster;
  } strobes_t;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_STATUS,
    RD_PENDING,
    RD_ENABLE,
    RD_VECTOR,
    RD_MASTER
  } rdSel_e;

endpackage

// File: rtl/vintc_ctrl.sv
module vintc_ctrl
  import vintc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobes_t          strb,
  output rdSel_e            rdSel
);

  logic       aligned;
  logic       inWindow;
  logic       mapped;
  logic [2:0] wordIdx;

  assign aligned  = (busAddr[1:0] == 2'b00);
  assign inWindow = ((busAddr >> 5) == '0);
  assign mapped   = aligned && inWindow;
  assign wordIdx  = busAddr[4:2];

  always_comb begin
    strb  = '0;
    rdSel = RD_ZERO;
    if (mapped) begin
      unique case (wordIdx)
        OFS_STATUS[4:2]:  rdSel = RD_STATUS;
        OFS_PENDING[4:2]: rdSel = RD_PENDING;
        OFS_ENABLE[4:2]: begin
          rdSel         = RD_ENABLE;
          strb.wrEnable = busWe;
        end
        OFS_ACK[4:2]:     strb.wrAck     = busWe;
        OFS_SETEN[4:2]:   strb.setEnable = busWe;
        OFS_CLREN[4:2]:   strb.clrEnable = busWe;
        OFS_VECTOR[4:2]:  rdSel = RD_VECTOR;
        OFS_MASTER[4:2]: begin
          rdSel         = RD_MASTER;
          strb.wrMaster = busWe;
        end
        default:          rdSel = RD_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/vintc_datapath.sv
module vintc_datapath
  import vintc_pkg::*;
#(
  parameter int          NUM_IN    = 8,
  parameter logic [31:0] EDGE_MASK = 32'hFFFF_FF30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] irqIn,
  input  logic [31:0]       busWdata,
  input  strobes_t          strb,
  input  rdSel_e            rdSel,
  output logic [31:0]       busRdata,
  output logic              irqOut,
  output logic [NUM_IN-1:0] statusQ,
  output logic [NUM_IN-1:0] enableQ,
  output logic [1:0]        masterQ
);

  localparam logic [NUM_IN-1:0] EDGE_BITS = EDGE_MASK[NUM_IN-1:0];
  localparam int               IDX_W     = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  logic [NUM_IN-1:0] irqPrev;
  logic [NUM_IN-1:0] req;
  logic [NUM_IN-1:0] ackMask;
  logic [NUM_IN-1:0] statusD;
  logic [NUM_IN-1:0] enableD;
  logic [1:0]        masterD;
  logic [NUM_IN-1:0] pendingW;
  logic [NUM_IN-1:0] wdataN;
  logic              anyPending;
  logic [IDX_W-1:0]  lowIdx;
  logic [31:0]       vectorW;

  assign wdataN = busWdata[NUM_IN-1:0];

  generate
    if (NUM_IN < 32) begin : g_unusedData
      logic unusedHighData;
      assign unusedHighData = ^busWdata[31:NUM_IN];
    end
  endgenerate

  // Request capture: level lines while high, edge lines on a rise
  always_comb begin
    req = (irqIn & ~EDGE_BITS) | (irqIn & ~irqPrev & EDGE_BITS);
  end

  always_comb begin
    ackMask = strb.wrAck ? wdataN : '0;
    statusD = (statusQ & ~ackMask) | req;
  end

  always_comb begin
    enableD = enableQ;
    if (strb.wrEnable) begin
      enableD = wdataN;
    end else if (strb.setEnable) begin
      enableD = enableQ | wdataN;
    end else if (strb.clrEnable) begin
      enableD = enableQ & ~wdataN;
    end
  end

  assign masterD = strb.wrMaster ? busWdata[1:0] : masterQ;

  assign pendingW   = statusQ & enableQ;
  assign anyPending = |pendingW;

  // Fixed priority: lowest index wins
  always_comb begin
    lowIdx = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (pendingW[i]) begin
        lowIdx = IDX_W'(i);
      end
    end
  end

  assign vectorW = anyPending ? 32'(lowIdx) : NO_VECTOR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPrev <= '0;
      statusQ <= '0;
      enableQ <= '0;
      masterQ <= '0;
      irqOut  <= 1'b0;
    end else begin
      irqPrev <= irqIn & EDGE_BITS;
      statusQ <= statusD;
      enableQ <= enableD;
      masterQ <= masterD;
      irqOut  <= (&masterQ) && anyPending;
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_STATUS:  busRdata = 32'(statusQ);
      RD_PENDING: busRdata = 32'(pendingW);
      RD_ENABLE:  busRdata = 32'(enableQ);
      RD_VECTOR:  busRdata = vectorW;
      RD_MASTER:  busRdata = 32'(masterQ);
      default:    busRdata = '0;
    endcase
  end

endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vintc_pkg::*;
#(
  parameter int          NUM_IN    = 8,
  parameter logic [31:0] EDGE_MASK = 32'hFFFF_FF30,
  parameter int          ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] irqIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqOut
);

  strobes_t          strb;
  rdSel_e            rdSel;
  logic [NUM_IN-1:0] statusQ;
  logic [NUM_IN-1:0] enableQ;
  logic [1:0]        masterQ;

  vintc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  vintc_datapath #(.NUM_IN(NUM_IN), .EDGE_MASK(EDGE_MASK)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .irqIn    (irqIn),
    .busWdata (busWdata),
    .strb     (strb),
    .rdSel    (rdSel),
    .busRdata (busRdata),
    .irqOut   (irqOut),
    .statusQ  (statusQ),
    .enableQ  (enableQ),
    .masterQ  (masterQ)
  );

endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
  parameter int          NUM_IN    = 8,
  parameter logic [31:0] EDGE_MASK = 32'hFFFF_FF30,
  parameter int          ADDR_W    = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_IN-1:0] irqIn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              irqOut,
  input logic [NUM_IN-1:0] statusQ,
  input logic [NUM_IN-1:0] enableQ,
  input logic [1:0]        masterQ
);

  localparam logic [NUM_IN-1:0] EDGE_BITS = EDGE_MASK[NUM_IN-1:0];
  localparam logic [ADDR_W-1:0] A_SETEN   = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_CLREN   = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_VECTOR  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_MASTER  = ADDR_W'(8'h1C);

  // R9
  irq_follows_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == $past((&masterQ) && (|(statusQ & enableQ))));

  // R3
  set_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_SETEN) |=>
      ((enableQ & $past(busWdata[NUM_IN-1:0])) == $past(busWdata[NUM_IN-1:0])));

  // R3
  clr_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_CLREN) |=>
      ((enableQ & $past(busWdata[NUM_IN-1:0])) == '0));

  // R5
  edge_rise_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~$past(statusQ) & EDGE_BITS) &
     ~($past(irqIn) & ~$past(irqIn, 2))) == '0);

  // R8
  empty_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == A_VECTOR && (statusQ & enableQ) == '0) |-> busRdata == 32'hFFFF_FFFF);

  // R9
  master_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_MASTER) |=> masterQ == $past(busWdata[1:0]));

endmodule

bind vec_intc vec_intc_chk #(.NUM_IN(NUM_IN), .EDGE_MASK(EDGE_MASK), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .irqIn    (irqIn),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .irqOut   (irqOut),
  .statusQ  (statusQ),
  .enableQ  (enableQ),
  .masterQ  (masterQ)
);

// File: tb/vec_intc_bench.sv
`timescale 1ns/1ps
module vec_intc_bench;

  localparam int          NUM_IN    = 8;
  localparam logic [31:0] EDGE_MASK = 32'hFFFF_FF30; // inputs 4,5 edge
  localparam int          ADDR_W    = 6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NUM_IN-1:0] irqIn = '0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWe = 1'b0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic              irqOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vec_intc #(.NUM_IN(NUM_IN), .EDGE_MASK(EDGE_MASK), .ADDR_W(ADDR_W)) u_vec_intc (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr  = ADDR_W'(a);
    busWdata = d;
    busWe    = 1'b1;
    @(negedge clk);
    busWe    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    busAddr = ADDR_W'(a);
    #1;
    v = busRdata;
  endtask

  task automatic rdCheck(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic drive(input int idx, input logic val);
    @(negedge clk);
    irqIn[idx] = val;
    @(negedge clk);
  endtask

  task automatic testReset();
    rdCheck("R1 status", 8'h00, 32'h0);
    rdCheck("R1 enable", 8'h08, 32'h0);
    rdCheck("R1 master", 8'h1C, 32'h0);
    rdCheck("R1 vector", 8'h18, 32'hFFFF_FFFF);
    check("R1 irqOut", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic testEnable();
    wr(8'h10, 32'h05);
    rdCheck("R3 set", 8'h08, 32'h05);
    wr(8'h10, 32'h02);
    rdCheck("R3 set keeps others", 8'h08, 32'h07);
    wr(8'h14, 32'h01);
    rdCheck("R3 clear keeps others", 8'h08, 32'h06);
    wr(8'h08, 32'h81);
    rdCheck("R3 direct write", 8'h08, 32'h81);
    wr(8'h10, 32'hFFFF_FFFF);
    rdCheck("R10 enable high bits", 8'h08, 32'hFF);
    wr(8'h14, 32'hFFFF_FFFF);
    rdCheck("R3 clear all", 8'h08, 32'h0);
  endtask

  task automatic testLevel();
    drive(1, 1'b1);
    rdCheck("R6 level latch", 8'h00, 32'h02);
    wr(8'h0C, 32'h02);
    rdCheck("R6 relatch while high", 8'h00, 32'h02);
    drive(1, 1'b0);
    wr(8'h0C, 32'h02);
    rdCheck("R4 ack level low", 8'h00, 32'h0);
  endtask

  task automatic testEdge();
    drive(4, 1'b1);
    rdCheck("R5 edge latch", 8'h00, 32'h10);
    wr(8'h0C, 32'h10);
    rdCheck("R5 held high no relatch", 8'h00, 32'h0);
    drive(4, 1'b0);
    rdCheck("R5 fall no latch", 8'h00, 32'h0);
    drive(4, 1'b1);
    rdCheck("R5 second rise", 8'h00, 32'h10);
    drive(4, 1'b0);
  endtask

  task automatic testDecode();
    // status holds 0x10 here, enable 0
    wr(8'h00, 32'h0);
    wr(8'h00, 32'hFF);
    rdCheck("R2 status write ignored", 8'h00, 32'h10);
    wr(8'h04, 32'hFF);
    wr(8'h18, 32'hFF);
    rdCheck("R2 pending/vector write ignored", 8'h00, 32'h10);
    wr(8'h08, 32'h0C);
    wr(8'h11, 32'hFF);
    wr(8'h30, 32'hFF);
    wr(8'h2C, 32'h0);
    rdCheck("R2 misaligned/unmapped write ignored", 8'h08, 32'h0C);
    rdCheck("R2 unmapped read", 8'h30, 32'h0);
    rdCheck("R2 ack read zero", 8'h0C, 32'h0);
    rdCheck("R2 misaligned read", 8'h09, 32'h0);
    wr(8'h08, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
  endtask

  task automatic testVector();
    wr(8'h08, 32'h30);
    drive(2, 1'b1);
    drive(5, 1'b1);
    drive(4, 1'b1);
    rdCheck("R7 pending", 8'h04, 32'h30);
    rdCheck("R10 status", 8'h00, 32'h34);
    rdCheck("R8 lowest", 8'h18, 32'h4);
    wr(8'h0C, 32'h10);
    rdCheck("R8 next", 8'h18, 32'h5);
    wr(8'h0C, 32'h20);
    rdCheck("R8 none", 8'h18, 32'hFFFF_FFFF);
    rdCheck("R7 pending empty", 8'h04, 32'h0);
    drive(2, 1'b0);
    drive(4, 1'b0);
    drive(5, 1'b0);
    wr(8'h0C, 32'hFFFF_FFFF);
    rdCheck("R4 ack all", 8'h00, 32'h0);
  endtask

  task automatic testMaster();
    wr(8'h1C, 32'hFFFF_FFFF);
    rdCheck("R9 readback", 8'h1C, 32'h3);
    wr(8'h1C, 32'h1);
    drive(4, 1'b1);
    @(negedge clk);
    check("R9 one bit no irq", {31'b0, irqOut}, 32'h0);
    wr(8'h1C, 32'h3);
    check("R9 latency", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    check("R9 irq high", {31'b0, irqOut}, 32'h1);
    wr(8'h0C, 32'h10);
    @(negedge clk);
    check("R9 irq drops", {31'b0, irqOut}, 32'h0);
    drive(4, 1'b0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEnable();
    testLevel();
    testEdge();
    testDecode();
    testVector();
    testMaster();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule